// File: doc/BRIEF.md
# DMA Block-Mode Address and Count Sequencer

This block is the address and count engine of a single DMA channel working in block mode. Software sets up a source start address, a destination start address, a block length M (unit transfers per block), a block count N, a unit size (byte or word) and per-side stepping controls. It then pulses `start_i`. Each rising request on `req_i` while the channel is idle starts a burst of M units. Every unit is a read beat at the source address followed by a write beat at the destination address.

One side is the repeating block area, chosen by `cfg_blk_dst_i`. Its address returns to its start value at the end of every block. The other side keeps advancing across all N blocks. After the N-th block the channel disables itself and raises `done_o`. If interrupts are enabled, it also raises `irq_o`.

Beats leave on a valid/ready stream. `bus_valid_o` stays high and `bus_addr_o`, `bus_we_o` and `bus_word_o` stay frozen until the cycle in which `bus_ready_i` is also high. That clock edge completes the beat. Holding `bus_ready_i` low stalls the sequencer indefinitely and loses nothing. Configuration, request and status pins are plain levels and pulses.

Top module: `dma_blk_seq`

## Requirements
- R1: A `start_i` pulse is refused in these cases: word size (`cfg_word_i`=1) with bit 0 of either start address set, M=0, or N=0. A refused start sets `err_o`, leaves `busy_o` low and produces no bus beats. An accepted start clears `err_o` and `done_o` and sets `busy_o`. Every word beat carries an even address.
- R2: One accepted request produces exactly M units. Each unit is a read beat (`bus_we_o`=0) at the source followed by a write beat (`bus_we_o`=1) at the destination, giving 2·M beats. After the last beat, `bus_valid_o` drops until the next request.
- R3: A request is ignored while a burst is in progress or while `busy_o` is low, and no extra beat results. `bus_valid_o` is never high while `busy_o` is low.
- R4: The step of a side is applied only when that side's step enable is set. Its size is 1 for bytes and 2 for words, and it subtracts when the side's down bit is set. `bus_word_o` shows the unit size. Addresses wrap modulo 2^AW.
- R5: With `cfg_blk_dst_i`=0 the source side is the block area, and with 1 the destination side is. Unit u of any block (u=0..M-1) uses block-side address start + step·u.
- R6: The non-block side uses start + step·k for the k-th unit overall (k=0..M·N−1). Its last unit is therefore at start + step·(M·N−1).
- R7: When the last unit of block N completes, `busy_o` clears and `done_o` sets in the same edge.
- R8: At that completion `irq_o` sets if `cfg_irq_en_i` is high in that cycle. `irq_o` and `done_o` then stay set until an `irq_clr_i` pulse or a new `start_i`.
- R9: While `bus_valid_o`=1 and `bus_ready_i`=0, the beat's valid, address and direction hold unchanged into the next cycle.
- R10: After reset `busy_o`, `done_o`, `err_o`, `irq_o` and `bus_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load configuration and arm channel |
| cfg_src_i | input | AW | Source start address |
| cfg_dst_i | input | AW | Destination start address |
| cfg_bsz_i | input | MW | Units per block (M) |
| cfg_blk_i | input | NW | Number of blocks (N) |
| cfg_word_i | input | 1 | Unit size: 0 byte, 1 word |
| cfg_src_step_i | input | 1 | Source address steps per unit |
| cfg_src_down_i | input | 1 | Source steps downward |
| cfg_dst_step_i | input | 1 | Destination address steps per unit |
| cfg_dst_down_i | input | 1 | Destination steps downward |
| cfg_blk_dst_i | input | 1 | Block area: 0 source, 1 destination |
| cfg_irq_en_i | input | 1 | Raise interrupt at completion |
| req_i | input | 1 | Transfer request |
| irq_clr_i | input | 1 | Clear completion flag and interrupt |
| bus_valid_o | output | 1 | Beat valid |
| bus_ready_i | input | 1 | Beat accepted |
| bus_we_o | output | 1 | 1 write beat, 0 read beat |
| bus_word_o | output | 1 | Beat size is word |
| bus_addr_o | output | AW | Beat address |
| busy_o | output | 1 | Channel armed |
| done_o | output | 1 | All blocks transferred |
| err_o | output | 1 | Last start refused |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `start_i` and `irq_clr_i` are single-cycle pulses. They also assume that configuration inputs are stable in the cycle `start_i` is high, and that `bus_ready_i` may toggle freely. The stimulus therefore drives configuration only around start pulses. It then randomises `bus_ready_i` and `req_i` every cycle, including requests during bursts and after completion. M and N are kept small so that many whole jobs fit in the run. Directed jobs cover refused starts, single-unit blocks, both block sides and downward word stepping.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
  localparam int NUM_SIDES = 2;

  function automatic logic [1:0] unit_bytes(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_blk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          adv_i,
  input  logic          restore_i,
  input  logic          inc_en_i,
  input  logic          dec_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, addr_q, step;

  assign step   = AW'(unit_bytes(word_i));
  assign addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= start_i;
      addr_q <= start_i;
    end else if (restore_i) begin
      addr_q <= base_q;
    end else if (adv_i && inc_en_i) begin
      addr_q <= dec_i ? addr_q - step : addr_q + step;
    end
  end

  AST_RESTORE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i && !load_i |=> addr_q == base_q); // R5
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i && !load_i && !restore_i |=> $stable(addr_q)); // R4
endmodule

// File: rtl/dma_blk_counter.sv
module dma_blk_counter #(
  parameter int MW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [MW-1:0] m_i,
  input  logic [NW-1:0] n_i,
  input  logic          unit_i,
  output logic          blk_end_o,
  output logic          all_end_o,
  output logic [MW-1:0] bsz_o,
  output logic [NW-1:0] blk_o
);
  logic [MW-1:0] bsz_q, reload_q;
  logic [NW-1:0] blk_q;

  assign blk_end_o = unit_i && (bsz_q == MW'(1));
  assign all_end_o = blk_end_o && (blk_q == NW'(1));
  assign bsz_o     = bsz_q;
  assign blk_o     = blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsz_q    <= '0;
      reload_q <= '0;
      blk_q    <= '0;
    end else if (load_i) begin
      bsz_q    <= m_i;
      reload_q <= m_i;
      blk_q    <= n_i;
    end else if (unit_i) begin
      if (blk_end_o) begin
        bsz_q <= reload_q;
        blk_q <= blk_q - NW'(1);
      end else begin
        bsz_q <= bsz_q - MW'(1);
      end
    end
  end

  AST_BSZ_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end_o && !load_i |=> bsz_q == reload_q); // R2
  AST_BLK_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    unit_i && !blk_end_o && !load_i |=> $stable(blk_q)); // R7
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
  import dma_blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [MW-1:0] cfg_bsz_i,
  input  logic [NW-1:0] cfg_blk_i,
  input  logic          cfg_word_i,
  input  logic          cfg_src_step_i,
  input  logic          cfg_src_down_i,
  input  logic          cfg_dst_step_i,
  input  logic          cfg_dst_down_i,
  input  logic          cfg_blk_dst_i,
  input  logic          cfg_irq_en_i,
  input  logic          req_i,
  input  logic          irq_clr_i,
  output logic          bus_valid_o,
  input  logic          bus_ready_i,
  output logic          bus_we_o,
  output logic          bus_word_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          irq_o
);
  seq_state_e st_q;
  logic en_q, done_q, err_q, irq_q;
  logic word_q, blk_dst_q;
  logic [NUM_SIDES-1:0] step_q, down_q;
  logic bad_cfg, load, unit_done, blk_end, all_end;
  logic [MW-1:0] cnt_bsz;
  logic [NW-1:0] cnt_blk;
  logic [AW-1:0] side_start [NUM_SIDES];
  logic [AW-1:0] side_addr  [NUM_SIDES];

  assign bad_cfg = (cfg_word_i && (cfg_src_i[0] || cfg_dst_i[0]))
                || (cfg_bsz_i == '0) || (cfg_blk_i == '0);
  assign load      = start_i && !bad_cfg;
  assign unit_done = (st_q == ST_WRITE) && bus_ready_i && !start_i;

  assign side_start[SIDE_SRC] = cfg_src_i;
  assign side_start[SIDE_DST] = cfg_dst_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic IS_DST = (s == SIDE_DST);
    dma_addr_gen #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .start_i   (side_start[s]),
      .adv_i     (unit_done),
      .restore_i (blk_end && (blk_dst_q == IS_DST)),
      .inc_en_i  (step_q[s]),
      .dec_i     (down_q[s]),
      .word_i    (word_q),
      .addr_o    (side_addr[s])
    );
  end

  dma_blk_counter #(.MW(MW), .NW(NW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .m_i       (cfg_bsz_i),
    .n_i       (cfg_blk_i),
    .unit_i    (unit_done),
    .blk_end_o (blk_end),
    .all_end_o (all_end),
    .bsz_o     (cnt_bsz),
    .blk_o     (cnt_blk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      en_q      <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
      word_q    <= 1'b0;
      blk_dst_q <= 1'b0;
      step_q    <= '0;
      down_q    <= '0;
    end else if (start_i) begin
      st_q      <= ST_IDLE;
      en_q      <= !bad_cfg;
      err_q     <= bad_cfg;
      done_q    <= 1'b0;
      irq_q     <= 1'b0;
      word_q    <= cfg_word_i;
      blk_dst_q <= cfg_blk_dst_i;
      step_q    <= {cfg_dst_step_i, cfg_src_step_i};
      down_q    <= {cfg_dst_down_i, cfg_src_down_i};
    end else begin
      if (irq_clr_i) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      unique case (st_q)
        ST_IDLE:  if (en_q && req_i) st_q <= ST_READ;
        ST_READ:  if (bus_ready_i) st_q <= ST_WRITE;
        ST_WRITE: if (bus_ready_i) st_q <= blk_end ? ST_IDLE : ST_READ;
        default:  st_q <= ST_IDLE;
      endcase
      if (all_end) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
        irq_q  <= cfg_irq_en_i;
      end
    end
  end

  assign bus_valid_o = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WRITE);
  assign bus_word_o  = word_q;
  assign bus_addr_o  = (st_q == ST_WRITE) ? side_addr[SIDE_DST] : side_addr[SIDE_SRC];
  assign busy_o      = en_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign irq_o       = irq_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_valid_o); // R3
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && !bus_ready_i && !start_i |=> bus_valid_o && $stable(bus_addr_o) && $stable(bus_we_o)); // R9
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && bus_word_o |-> !bus_addr_o[0]); // R1
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o); // R7
  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i && !start_i |=> irq_o); // R8
  AST_COUNTS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_bsz != '0) && (cnt_blk != '0)); // R7
endmodule

// File: tb/dma_blk_seq_tb_top.sv
`timescale 1ns/1ps
module dma_blk_seq_tb_top;
  localparam int AW = 16, MW = 8, NW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, req_i = 0, irq_clr_i = 0, bus_ready_i = 0;
  logic [AW-1:0] cfg_src_i = 0, cfg_dst_i = 0;
  logic [MW-1:0] cfg_bsz_i = 0;
  logic [NW-1:0] cfg_blk_i = 0;
  logic cfg_word_i = 0, cfg_src_step_i = 0, cfg_src_down_i = 0;
  logic cfg_dst_step_i = 0, cfg_dst_down_i = 0, cfg_blk_dst_i = 0, cfg_irq_en_i = 0;
  logic bus_valid_o, bus_we_o, bus_word_o, busy_o, done_o, err_o, irq_o;
  logic [AW-1:0] bus_addr_o;

  int checks = 0, failures = 0;
  int unsigned seed_sink;

  always #4 clk = ~clk;

  dma_blk_seq #(.AW(AW), .MW(MW), .NW(NW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input bit en,
                                             input bit down, input bit word, input int idx);
    int delta;
    delta = en ? idx * (word ? 2 : 1) : 0;
    return down ? base - AW'(delta) : base + AW'(delta);
  endfunction

  // Bench model state
  bit active, armed;
  int k_units, beats;
  bit phase_wr;

  task automatic tick(input bit want_req);
    bit accept, hs;
    int u, kk;
    logic [AW-1:0] es, ed;
    @(negedge clk);
    req_i = want_req;
    bus_ready_i = ($urandom % 4) != 0;
    #1;
    chk(bus_valid_o == active, "R3 valid vs burst", bus_valid_o, active);
    accept = want_req && armed && !active;
    hs = bus_valid_o && bus_ready_i;
    if (hs) begin
      beats++;
      u  = k_units % int'(cfg_bsz_i);
      kk = k_units;
      es = exp_addr(cfg_src_i, cfg_src_step_i, cfg_src_down_i, cfg_word_i, cfg_blk_dst_i ? kk : u);
      ed = exp_addr(cfg_dst_i, cfg_dst_step_i, cfg_dst_down_i, cfg_word_i, cfg_blk_dst_i ? u : kk);
      chk(bus_we_o == phase_wr, "R2 beat direction", bus_we_o, phase_wr);
      chk(bus_word_o == cfg_word_i, "R4 beat size", bus_word_o, cfg_word_i);
      if (!phase_wr)
        chk(bus_addr_o == es, cfg_blk_dst_i ? "R6 source address" : "R5 source address", bus_addr_o, es);
      else
        chk(bus_addr_o == ed, cfg_blk_dst_i ? "R5 dest address" : "R6 dest address", bus_addr_o, ed);
      if (phase_wr) begin
        k_units++;
        if (k_units % int'(cfg_bsz_i) == 0) active = 0;
        if (k_units == int'(cfg_bsz_i) * int'(cfg_blk_i)) armed = 0;
      end
      phase_wr = !phase_wr;
    end
    if (accept) active = 1;
  endtask

  task automatic do_start(input bit expect_bad);
    @(negedge clk);
    req_i = 0; bus_ready_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    #1;
    chk(err_o == expect_bad, "R1 err after start", err_o, expect_bad);
    chk(busy_o == !expect_bad, "R1 busy after start", busy_o, !expect_bad);
    chk(done_o == 0, "R1 done cleared", done_o, 0);
    armed = !expect_bad; active = 0; k_units = 0; beats = 0; phase_wr = 0;
  endtask

  task automatic run_job(input logic [AW-1:0] s, input logic [AW-1:0] d, input int m, input int n,
                         input bit w, input bit ss, input bit sd, input bit ds, input bit dd,
                         input bit bd, input bit ie);
    int guard;
    bit bad;
    cfg_src_i = s; cfg_dst_i = d; cfg_bsz_i = MW'(m); cfg_blk_i = NW'(n);
    cfg_word_i = w; cfg_src_step_i = ss; cfg_src_down_i = sd;
    cfg_dst_step_i = ds; cfg_dst_down_i = dd; cfg_blk_dst_i = bd; cfg_irq_en_i = ie;
    bad = (w && (s[0] || d[0])) || m == 0 || n == 0;
    do_start(bad);
    guard = 0;
    while (armed && guard < 5000) begin
      tick(($urandom % 3) == 0);
      guard++;
    end
    chk(guard < 5000, "R2 job progress", guard, 0);
    repeat (12) tick(($urandom % 2) == 0);
    chk(beats == (bad ? 0 : 2 * m * n), "R2 beat total", beats, bad ? 0 : 2 * m * n);
    chk(busy_o == 0, "R7 busy cleared", busy_o, 0);
    chk(done_o == !bad, "R7 done set", done_o, !bad);
    chk(irq_o == (!bad && ie), "R8 irq at end", irq_o, !bad && ie);
    chk(err_o == bad, "R1 err kept", err_o, bad);
    if (!bad) begin
      @(negedge clk); irq_clr_i = 1;
      @(negedge clk); irq_clr_i = 0; #1;
      chk(irq_o == 0 && done_o == 0, "R8 clear", {irq_o, done_o}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h5EED_1234);
    #20; rst_n = 1;
    @(negedge clk); #1;
    chk(!busy_o && !done_o && !err_o && !irq_o && !bus_valid_o, "R10 reset state",
        {busy_o, done_o, err_o, irq_o, bus_valid_o}, 0);
    // requests before any start are ignored (R3)
    repeat (5) tick(1);
    // directed corner cases
    run_job(16'h1001, 16'h2000, 3, 2, 1, 1, 0, 1, 0, 0, 1);   // R1 misaligned word
    run_job(16'h1000, 16'h2000, 0, 2, 0, 1, 0, 1, 0, 0, 1);   // R1 M zero
    run_job(16'h1000, 16'h2000, 3, 0, 0, 1, 0, 1, 0, 0, 1);   // R1 N zero
    run_job(16'h1000, 16'h2000, 1, 1, 0, 1, 0, 1, 0, 0, 1);   // single unit
    run_job(16'h1000, 16'h2000, 4, 3, 0, 1, 0, 1, 0, 0, 1);   // R5 source block area
    run_job(16'h1000, 16'h2000, 3, 4, 1, 1, 0, 1, 1, 1, 0);   // R5 dest block, word down, no irq
    run_job(16'h0002, 16'hFFFE, 2, 3, 1, 1, 1, 1, 0, 1, 1);   // R4 wrap both ways
    run_job(16'h0400, 16'h0800, 1, 5, 0, 1, 0, 0, 0, 0, 1);   // R6 fixed dest, M=1
    // random jobs
    for (int j = 0; j < 40; j++) begin
      logic [AW-1:0] rs, rd;
      bit rw;
      rw = $urandom % 2;
      rs = AW'($urandom); rd = AW'($urandom);
      if (rw && ($urandom % 4) != 0) begin rs[0] = 0; rd[0] = 0; end
      run_job(rs, rd, 1 + $urandom % 6, 1 + $urandom % 5, rw, $urandom % 2, $urandom % 2,
              $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule